// File: doc/BRIEF.md
# Masked GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of parameterised width (32 bits by default). It is controlled through a plain register bus, one write per cycle, with one strobe per byte lane. Software sets the direction of each pin and writes an output register. It can also raise or lower any group of output bits in a single write, through dedicated set and clear addresses. A mask register shields chosen bits, so a write cannot touch them. Read data comes back in the same cycle: either the stored output value or the synchronised level seen on the pins.

Each pin feeds a two-stage synchroniser. An edge is detected by comparing the synchronised level with its value one cycle earlier. Separate rising and falling enables select which edges a pin reports. A detected, enabled edge sets a sticky status bit, and software clears that bit by writing a 1 to it. The single interrupt line is high while any status bit is set. A level-sensitive wake request goes high in the same cycle that an enabled edge is detected, one cycle before the status bit sets, and it stays high for as long as the interrupt does.

No state machine is needed. The layout still follows the house pattern: an enumerated register index decoded with `unique case`, one sequential process per storage group, and a separate combinational process for the read data.

Register index (`bus_addr`): 0 direction, 1 output, 2 set, 3 clear, 4 mask, 5 pin levels, 6 rising enable, 7 falling enable, 8 rising status, 9 falling status. The set and clear addresses, and any index above 9, read as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, direction, output, mask, both enable registers and both status registers are all zero, so `pin_oe`, `pin_out`, `irq` and `wake_req` are low.
- R2: A write to index 2 (set) drives high every output bit written as 1. A write to index 3 (clear) drives low every output bit written as 1. Bits written as 0 keep their value. Both indices read as zero.
- R3: Bits that are 1 in the mask register (index 4) are not changed by writes to the output, set or clear indices. Masked bits read as 0 at the pin-level index 5.
- R4: `bus_strb[i]` enables bits 8i+7..8i of every write. A write leaves the bits of disabled lanes unchanged.
- R5: Index 1 reads the output register. Index 5 reads the pin levels two clock edges after they are applied, even on pins driven as outputs. `pin_oe` equals the direction register and `pin_out` equals the output register.
- R6: With rising enable (index 6) bit n set, a 0-to-1 change on `pin_in[n]` sets rising status bit n (index 8) on the third clock edge after the change.
- R7: With falling enable (index 7) bit n set, a 1-to-0 change on `pin_in[n]` sets falling status bit n (index 9) on the third edge after the change. When both enables are set, both directions report.
- R8: Status bits stay set until a write of 1 to that bit at index 8 or 9. Writing 0 has no effect. A new edge in the same cycle as the clear leaves the bit set.
- R9: `irq` is high exactly when any rising or falling status bit is set.
- R10: `wake_req` is high in the cycle where an enabled edge is detected, one cycle before the status bit sets, and stays high while `irq` is high.
- R11: An edge whose direction is not enabled sets no status bit and raises neither `irq` nor `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | WIDTH | Write data |
| bus_strb | input | WIDTH/8 | Byte lane enables |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, same cycle |
| pin_in | input | WIDTH | Pad input levels, asynchronous |
| pin_out | output | WIDTH | Output register to pads |
| pin_oe | output | WIDTH | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt |
| wake_req | output | 1 | Level wake request |

## Verification
The hardest case to reach from the ports is an edge detected in the very cycle that software clears the same status bit. The edge must travel through two synchroniser stages and the edge comparator before it lines up with the write. The stimulus changes the pin just after a falling clock edge and lets two rising edges pass. It then issues the clear write so that the write lands on the third edge, together with the detected edge, and checks that the bit is still set.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        REG_DIR     = 4'd0,
        REG_OUT     = 4'd1,
        REG_SET     = 4'd2,
        REG_CLR     = 4'd3,
        REG_MASK    = 4'd4,
        REG_PINS    = 4'd5,
        REG_RISE_EN = 4'd6,
        REG_FALL_EN = 4'd7,
        REG_RISE_ST = 4'd8,
        REG_FALL_ST = 4'd9
    } gpio_reg_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] level_prev_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign level_o      = stage_q[STAGES-1];
    assign level_prev_o = prev_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_reg_e        reg_sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] lane_bits,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] rise_en_q,
    output logic [WIDTH-1:0] fall_en_q
);
    logic [WIDTH-1:0] out_wbits;

    assign out_wbits = lane_bits & ~mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            mask_q    <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_DIR:     dir_q     <= (dir_q     & ~lane_bits) | (wdata & lane_bits);
                REG_MASK:    mask_q    <= (mask_q    & ~lane_bits) | (wdata & lane_bits);
                REG_RISE_EN: rise_en_q <= (rise_en_q & ~lane_bits) | (wdata & lane_bits);
                REG_FALL_EN: fall_en_q <= (fall_en_q & ~lane_bits) | (wdata & lane_bits);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_OUT: out_q <= (out_q & ~out_wbits) | (wdata & out_wbits);
                REG_SET: out_q <= out_q | (wdata & out_wbits);
                REG_CLR: out_q <= out_q & ~(wdata & out_wbits);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] level_prev,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] rise_clr,
    input  logic [WIDTH-1:0] fall_clr,
    output logic [WIDTH-1:0] rise_st_q,
    output logic [WIDTH-1:0] fall_st_q,
    output logic             edge_seen
);
    logic [WIDTH-1:0] rise_evt;
    logic [WIDTH-1:0] fall_evt;

    assign rise_evt  = level & ~level_prev & rise_en;
    assign fall_evt  = ~level & level_prev & fall_en;
    assign edge_seen = |(rise_evt | fall_evt);

    // A fresh event wins over a clear landing in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_st_q <= '0;
            fall_st_q <= '0;
        end else begin
            rise_st_q <= (rise_st_q & ~rise_clr) | rise_evt;
            fall_st_q <= (fall_st_q & ~fall_clr) | fall_evt;
        end
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int LANES = WIDTH / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [LANES-1:0]  bus_strb,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq,
    output logic              wake_req
);
    gpio_reg_e        reg_sel;
    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] dir_q, out_q, mask_q, rise_en_q, fall_en_q;
    logic [WIDTH-1:0] level, level_prev;
    logic [WIDTH-1:0] rise_clr, fall_clr;
    logic [WIDTH-1:0] rise_st, fall_st;
    logic             edge_seen;

    assign reg_sel = gpio_reg_e'(bus_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{bus_strb[g]}};
    end

    assign rise_clr = (bus_wr_en && reg_sel == REG_RISE_ST) ? (bus_wdata & lane_bits) : '0;
    assign fall_clr = (bus_wr_en && reg_sel == REG_FALL_ST) ? (bus_wdata & lane_bits) : '0;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_in       (pin_in),
        .level_o      (level),
        .level_prev_o (level_prev)
    );

    gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .reg_sel   (reg_sel),
        .wdata     (bus_wdata),
        .lane_bits (lane_bits),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .mask_q    (mask_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q)
    );

    gpio_edge_status #(.WIDTH(WIDTH)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_prev (level_prev),
        .rise_en    (rise_en_q),
        .fall_en    (fall_en_q),
        .rise_clr   (rise_clr),
        .fall_clr   (fall_clr),
        .rise_st_q  (rise_st),
        .fall_st_q  (fall_st),
        .edge_seen  (edge_seen)
    );

    always_comb begin
        unique case (reg_sel)
            REG_DIR:     bus_rdata = dir_q;
            REG_OUT:     bus_rdata = out_q;
            REG_MASK:    bus_rdata = mask_q;
            REG_PINS:    bus_rdata = level & ~mask_q;
            REG_RISE_EN: bus_rdata = rise_en_q;
            REG_FALL_EN: bus_rdata = fall_en_q;
            REG_RISE_ST: bus_rdata = rise_st;
            REG_FALL_ST: bus_rdata = fall_st;
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe   = dir_q;
    assign irq      = |(rise_st | fall_st);
    assign wake_req = edge_seen | irq;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int LANES = WIDTH / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [REG_AW-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [LANES-1:0]  bus_strb,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic              irq,
    input logic              wake_req,
    input logic [WIDTH-1:0]  mask_q,
    input logic [WIDTH-1:0]  rise_st
);
    logic             past_ok;
    logic [WIDTH-1:0] lanes;
    logic [WIDTH-1:0] rclr_vec;
    logic [WIDTH-1:0] set_bits;
    logic             dir_wr;
    logic             set_full;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_ln
        assign lanes[g*8 +: 8] = {8{bus_strb[g]}};
    end

    assign rclr_vec = (bus_wr_en && bus_addr == REG_RISE_ST) ? (bus_wdata & lanes) : '0;
    assign set_bits = bus_wdata & ~mask_q;
    assign dir_wr   = bus_wr_en && bus_addr == REG_DIR;
    assign set_full = bus_wr_en && bus_addr == REG_SET && (&bus_strb);

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> (pin_oe == '0 && pin_out == '0 && !irq));

    p_setclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(set_full) |-> ((pin_out & $past(set_bits)) == $past(set_bits)));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0));

    p_dir_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(dir_wr) |-> $stable(pin_oe));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((($past(rise_st) & ~rise_st) & ~$past(rclr_vec)) == '0));

    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake_req);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .wake_req  (wake_req),
    .mask_q    (mask_q),
    .rise_st   (rise_st)
);

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
    localparam int CLK_P = 10;

    localparam logic [3:0] A_DIR = 4'd0, A_OUT = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                           A_MASK = 4'd4, A_PINS = 4'd5, A_REN = 4'd6, A_FEN = 4'd7,
                           A_RST = 4'd8, A_FST = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_strb;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;
    logic        wake_req;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_edge_port #(.WIDTH(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr  = a;
        bus_wdata = d;
        bus_strb  = s;
        bus_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            check("R1 register zero after reset", v, 32'h0);
        end
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq/wake", {30'h0, irq, wake_req}, 32'h0);
    endtask

    task automatic t_dir_out;
        logic [31:0] v;
        wr(A_DIR, 32'hA5A5A5A5, 4'hF);
        check("R5 pin_oe follows direction", pin_oe, 32'hA5A5A5A5);
        wr(A_OUT, 32'h12345678, 4'hF);
        rd(A_OUT, v);
        check("R5 output readback", v, 32'h12345678);
        check("R5 pin_out", pin_out, 32'h12345678);
    endtask

    task automatic t_setclr;
        logic [31:0] v;
        wr(A_SET, 32'h0000000F, 4'hF);
        check("R2 set ones only", pin_out, 32'h1234567F);
        wr(A_CLR, 32'h12000000, 4'hF);
        check("R2 clear ones only", pin_out, 32'h0034567F);
        rd(A_SET, v);
        check("R2 set index reads zero", v, 32'h0);
        rd(A_CLR, v);
        check("R2 clear index reads zero", v, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(A_OUT, 32'h0, 4'hF);
        wr(A_MASK, 32'h0000FFFF, 4'hF);
        wr(A_OUT, 32'hFFFFFFFF, 4'hF);
        check("R3 masked output write", pin_out, 32'hFFFF0000);
        wr(A_MASK, 32'h0, 4'hF);
        wr(A_OUT, 32'h000000FF, 4'hF);
        wr(A_MASK, 32'h0000FFFF, 4'hF);
        wr(A_CLR, 32'hFFFFFFFF, 4'hF);
        check("R3 masked clear", pin_out, 32'h000000FF);
        wr(A_SET, 32'h00FF0F00, 4'hF);
        check("R3 masked set", pin_out, 32'h00FF00FF);
        pin_in = 32'hDEADBEEF;
        cycles(1);
        rd(A_PINS, v);
        check("R5 pins not yet through synchroniser", v, 32'h0);
        cycles(1);
        rd(A_PINS, v);
        check("R3 masked pin read", v, 32'hDEAD0000);
        wr(A_MASK, 32'h0, 4'hF);
        rd(A_PINS, v);
        check("R5 pins on output-direction bits", v, 32'hDEADBEEF);
        pin_in = 32'h0;
        cycles(3);
    endtask

    task automatic t_lanes;
        logic [31:0] v;
        wr(A_DIR, 32'hFFFFFFFF, 4'hF);
        wr(A_DIR, 32'h00000000, 4'b0101);
        rd(A_DIR, v);
        check("R4 byte lanes on direction", v, 32'hFF00FF00);
        wr(A_OUT, 32'h00FF0000, 4'hF);
        wr(A_SET, 32'hFFFFFFFF, 4'b1000);
        check("R4 byte set", pin_out, 32'hFFFF0000);
        wr(A_CLR, 32'hFFFFFFFF, 4'b0011);
        check("R4 low half-word clear no effect", pin_out, 32'hFFFF0000);
        wr(A_CLR, 32'hFFFFFFFF, 4'b1100);
        check("R4 high half-word clear", pin_out, 32'h0);
    endtask

    task automatic t_rise;
        logic [31:0] v;
        wr(A_REN, 32'h1, 4'hF);
        pin_in[0] = 1'b1;
        cycles(2);
        check("R10 wake in detect cycle", {31'h0, wake_req}, 32'h1);
        check("R9 irq not yet", {31'h0, irq}, 32'h0);
        cycles(1);
        rd(A_RST, v);
        check("R6 rising status", v, 32'h1);
        check("R9 irq set", {31'h0, irq}, 32'h1);
        wr(A_RST, 32'h0, 4'hF);
        rd(A_RST, v);
        check("R8 zero write keeps status", v, 32'h1);
        wr(A_RST, 32'h1, 4'hF);
        rd(A_RST, v);
        check("R8 one write clears", v, 32'h0);
        check("R9/R10 irq and wake low", {30'h0, irq, wake_req}, 32'h0);
    endtask

    task automatic t_fall;
        logic [31:0] v;
        pin_in[4] = 1'b1;
        cycles(4);
        rd(A_FST, v);
        check("R11 disabled rise on pin 4", v, 32'h0);
        rd(A_RST, v);
        check("R11 disabled rise no rise status", v, 32'h0);
        check("R11 no irq/wake", {30'h0, irq, wake_req}, 32'h0);
        wr(A_FEN, 32'h10, 4'hF);
        pin_in[4] = 1'b0;
        cycles(3);
        rd(A_FST, v);
        check("R7 falling status", v, 32'h10);
        rd(A_RST, v);
        check("R7 no rising status", v, 32'h0);
        wr(A_FST, 32'h10, 4'hF);
    endtask

    task automatic t_both;
        logic [31:0] v;
        wr(A_REN, 32'h101, 4'hF);
        wr(A_FEN, 32'h110, 4'hF);
        pin_in[8] = 1'b1;
        cycles(3);
        rd(A_RST, v);
        check("R7 both-enable rise", v, 32'h100);
        pin_in[8] = 1'b0;
        cycles(3);
        rd(A_FST, v);
        check("R7 both-enable fall", v, 32'h100);
        wr(A_RST, 32'h100, 4'b0010);
        wr(A_FST, 32'h100, 4'b0001);
        rd(A_FST, v);
        check("R4 clear on disabled lane ignored", v, 32'h100);
        wr(A_FST, 32'h100, 4'b0010);
        check("R9 irq low after clears", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        pin_in[0] = 1'b0;
        cycles(3);
        pin_in[0] = 1'b1;
        cycles(3);
        pin_in[0] = 1'b0;
        cycles(3);
        pin_in[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(A_RST, 32'h1, 4'hF);
        rd(A_RST, v);
        check("R8 edge beats same-cycle clear", v, 32'h1);
        wr(A_RST, 32'h1, 4'hF);
        rd(A_RST, v);
        check("R8 later clear", v, 32'h0);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_wr_en = 1'b0;
        bus_addr = 4'h0;
        bus_wdata = 32'h0;
        bus_strb = 4'h0;
        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_dir_out;
        t_setclr;
        t_mask;
        t_lanes;
        t_rise;
        t_fall;
        t_both;
        t_collide;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule